// File: doc/BRIEF.md
# Serial Presence-Detect Slave Memory

This block is a 256-byte memory that sits on a two-wire serial bus as a slave. It holds identification data for a plug-in memory module. A host can read it back one byte at a time or in a continuous stream, and can write to it. The bus clock and data lines are sampled by the system clock, which is much faster than the bus. The block drives the data line through an open-drain enable: asserting `sda_oe_o` pulls the line low, and releasing it lets the line float high.

The 7-bit slave address is the fixed code 1010 in its upper four bits, followed by three strap inputs. Up to eight modules can therefore share one bus. The first byte after a write address loads the internal byte pointer. Later bytes in the same transfer are stored at that pointer, and the pointer advances after each one. A read address with no pointer phase streams bytes out from wherever the pointer was left. The host keeps a read going by acknowledging each byte and ends it by withholding the acknowledge.

A write-protect input shields the upper half of the array. After any transfer that carried data, the device stays silent to its own address for a programmable number of clock cycles. This window stands in for the storage programming time.

Top module: `spd_i2c_slave`

## Requirements
- R1: Before the first START after reset, bus activity of any pattern leaves `sda_oe_o` low. A STOP (SDA rising while SCL is high) releases SDA within one clock of being detected.
- R2: The device acknowledges, by driving SDA low during the ninth SCL pulse, only an address byte whose upper seven bits equal {1010, strap_i[2:0]}. A non-matching address gets no acknowledge, and the device stays released until the next START.
- R3: In a write, the first byte after the address sets the pointer. Each following byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R4: The pointer wraps from 255 to 0, for both writes and reads.
- R5: In a read, the device sends the byte at the pointer MSB first, releases SDA for the ninth pulse, and advances the pointer.
- R6: If the host acknowledges (SDA low on the ninth pulse), the next byte follows. If it does not, the device releases SDA and sends nothing more until the next START.
- R7: A read addressed without a pointer phase starts at the pointer left by the previous transfer.
- R8: While `wp_i` is high, data bytes aimed at addresses 128 to 255 are acknowledged but not stored. Addresses 0 to 127 are still stored.
- R9: After a STOP that ends a transfer containing at least one data byte, the device does not acknowledge its address for BUSY_CYCLES clock cycles. After that window it acknowledges again.
- R10: After reset, byte n of the array holds n XOR 0xA5 and the pointer is 0.
- R11: `sda_oe_o` changes only while the sampled SCL is low, except when it is released by a START or STOP.
- R12: A repeated START in the middle of a transfer restarts address reception, so a pointer write can be followed directly by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Board strap bits forming the low address bits |
| wp_i | input | 1 | Write protect for the upper 128 bytes |

## Verification
The assertions check the following on every cycle:
- The data-enable timing relative to the sampled clock line (R11).
- Release on STOP (R1).
- Silence during the busy window, and that the window opens only after a STOP (R9).
- That no protected byte is ever written (R8).
- Pointer advance after a stored byte (R3).

Content-level behaviour can only be shown by the bench scenarios. This covers address matching against the straps, the stored and returned byte values, pointer wrap, current-address continuation, the acknowledge-driven end of a read, and when the busy window expires. In these scenarios a host model drives full transfers and compares every byte against a behavioural copy of the array.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PTR_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } spd_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_WADDR,
        PH_WDATA
    } spd_phase_e;

    typedef struct packed {
        spd_state_e        state;
        spd_phase_e        phase;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [PTR_W-1:0]  ptr;
        logic              sda_oe;
        logic              rd_mode;
        logic              mack;
        logic              wr_pend;
    } spd_ctl_t;

    // Power-on content of array entry idx
    function automatic logic [BYTE_W-1:0] spd_default_byte(input int unsigned idx);
        logic [BYTE_W-1:0] low;
        low = BYTE_W'(idx);
        return low ^ 8'hA5;
    endfunction

endpackage

// File: rtl/spd_bus_sampler.sv
module spd_bus_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] scl_sh_d, scl_sh_q;
    logic [STAGES-1:0] sda_sh_d, sda_sh_q;
    logic              scl_prev_d, scl_prev_q;
    logic              sda_prev_d, sda_prev_q;

    always_comb begin
        scl_sh_d   = {scl_sh_q[LAST-1:0], scl_i};
        sda_sh_d   = {sda_sh_q[LAST-1:0], sda_i};
        scl_prev_d = scl_sh_q[LAST];
        sda_prev_d = sda_sh_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q   <= '1;
            sda_sh_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sh_q   <= scl_sh_d;
            sda_sh_q   <= sda_sh_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_lvl  = scl_sh_q[LAST];
    assign sda_lvl  = sda_sh_q[LAST];
    assign scl_rise = scl_lvl & ~scl_prev_q;
    assign scl_fall = ~scl_lvl & scl_prev_q;
    assign ev_start = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    assign ev_stop  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/spd_regfile.sv
module spd_regfile
    import spd_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q[i] <= DATA_W'(spd_default_byte(i));
            end else if (we && (waddr == ADDR_W'(i))) begin
                cell_q[i] <= wdata;
            end
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/spd_busy_timer.sv
module spd_busy_timer #(
    parameter int unsigned CYCLES = 2000,
    localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/spd_i2c_slave.sv
module spd_i2c_slave
    import spd_pkg::*;
#(
    parameter logic [3:0]  DEV_CODE    = 4'b1010,
    parameter int unsigned BUSY_CYCLES = 2000,
    parameter int unsigned PROT_BASE   = 128,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    localparam int unsigned DEPTH = 1 << PTR_W;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
    logic busy, busy_load;
    logic mem_we;
    logic [PTR_W-1:0]  mem_waddr, mem_raddr;
    logic [BYTE_W-1:0] mem_wdata, mem_rdata;
    logic addr_hit, in_prot;

    spd_ctl_t ctl_d, ctl_q;

    logic [PTR_W-1:0] ptr_now;
    logic             dev_phase;

    spd_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    spd_regfile #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    spd_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (busy_load),
        .busy  (busy)
    );

    assign mem_waddr = ctl_q.ptr;
    assign mem_raddr = ctl_q.ptr;
    assign mem_wdata = ctl_q.shreg;
    assign addr_hit  = (ctl_q.shreg[7:1] == {DEV_CODE, strap_i}) && !busy;
    assign in_prot   = wp_i && (int'(ctl_q.ptr) >= int'(PROT_BASE));

    always_comb begin
        ctl_d     = ctl_q;
        mem_we    = 1'b0;
        busy_load = 1'b0;

        if (ev_stop) begin
            busy_load     = ctl_q.wr_pend;
            ctl_d.state   = ST_IDLE;
            ctl_d.phase   = PH_DEV;
            ctl_d.sda_oe  = 1'b0;
            ctl_d.wr_pend = 1'b0;
        end else if (ev_start) begin
            ctl_d.state  = ST_RX;
            ctl_d.phase  = PH_DEV;
            ctl_d.bitcnt = '0;
            ctl_d.sda_oe = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE: begin
                    ctl_d = ctl_q;
                end

                ST_RX: begin
                    if (scl_rise && (ctl_q.bitcnt < 4'd8)) begin
                        ctl_d.shreg  = {ctl_q.shreg[BYTE_W-2:0], sda_lvl};
                        ctl_d.bitcnt = ctl_q.bitcnt + 4'd1;
                    end else if (scl_fall && (ctl_q.bitcnt == 4'd8)) begin
                        unique case (ctl_q.phase)
                            PH_DEV: begin
                                if (addr_hit) begin
                                    ctl_d.sda_oe  = 1'b1;
                                    ctl_d.rd_mode = ctl_q.shreg[0];
                                    ctl_d.state   = ST_RX_ACK;
                                end else begin
                                    ctl_d.state = ST_IDLE;
                                end
                            end
                            PH_WADDR: begin
                                ctl_d.ptr    = ctl_q.shreg;
                                ctl_d.sda_oe = 1'b1;
                                ctl_d.state  = ST_RX_ACK;
                            end
                            default: begin
                                mem_we        = !in_prot;
                                ctl_d.ptr     = ctl_q.ptr + PTR_W'(1);
                                ctl_d.wr_pend = 1'b1;
                                ctl_d.sda_oe  = 1'b1;
                                ctl_d.state   = ST_RX_ACK;
                            end
                        endcase
                    end
                end

                ST_RX_ACK: begin
                    if (scl_fall) begin
                        ctl_d.sda_oe = 1'b0;
                        ctl_d.bitcnt = '0;
                        if ((ctl_q.phase == PH_DEV) && ctl_q.rd_mode) begin
                            ctl_d.shreg  = mem_rdata;
                            ctl_d.sda_oe = ~mem_rdata[BYTE_W-1];
                            ctl_d.bitcnt = 4'd1;
                            ctl_d.ptr    = ctl_q.ptr + PTR_W'(1);
                            ctl_d.state  = ST_TX;
                        end else if (ctl_q.phase == PH_DEV) begin
                            ctl_d.phase = PH_WADDR;
                            ctl_d.state = ST_RX;
                        end else begin
                            ctl_d.phase = PH_WDATA;
                            ctl_d.state = ST_RX;
                        end
                    end
                end

                ST_TX: begin
                    if (scl_fall) begin
                        if (ctl_q.bitcnt == 4'd8) begin
                            ctl_d.sda_oe = 1'b0;
                            ctl_d.state  = ST_TX_ACK;
                        end else begin
                            ctl_d.shreg  = {ctl_q.shreg[BYTE_W-2:0], 1'b0};
                            ctl_d.sda_oe = ~ctl_q.shreg[BYTE_W-2];
                            ctl_d.bitcnt = ctl_q.bitcnt + 4'd1;
                        end
                    end
                end

                ST_TX_ACK: begin
                    if (scl_rise) begin
                        ctl_d.mack = ~sda_lvl;
                        if (sda_lvl) ctl_d.state = ST_IDLE;
                    end else if (scl_fall && ctl_q.mack) begin
                        ctl_d.shreg  = mem_rdata;
                        ctl_d.sda_oe = ~mem_rdata[BYTE_W-1];
                        ctl_d.bitcnt = 4'd1;
                        ctl_d.ptr    = ctl_q.ptr + PTR_W'(1);
                        ctl_d.state  = ST_TX;
                    end
                end

                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, phase: PH_DEV, bitcnt: '0, shreg: '0,
                       ptr: '0, sda_oe: 1'b0, rd_mode: 1'b0, mack: 1'b0,
                       wr_pend: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o  = ctl_q.sda_oe;
    assign ptr_now   = ctl_q.ptr;
    assign dev_phase = (ctl_q.phase == PH_DEV);

endmodule

// File: rtl/spd_i2c_slave_chk.sv
module spd_i2c_slave_chk #(
    parameter int unsigned PROT_BASE = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_lvl,
    input logic       ev_start,
    input logic       ev_stop,
    input logic       busy,
    input logic       dev_phase,
    input logic       mem_we,
    input logic [7:0] mem_waddr,
    input logic       wp,
    input logic [7:0] ptr
);
    AST_OE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!scl_lvl || $past(ev_start) || $past(ev_stop))); // R11

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_oe); // R1

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dev_phase) |-> !sda_oe); // R9

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ev_stop)); // R9

    AST_WP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp) |-> (int'(mem_waddr) < int'(PROT_BASE))); // R8

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr == $past(mem_waddr) + 8'd1)); // R3

endmodule

bind spd_i2c_slave spd_i2c_slave_chk #(.PROT_BASE(PROT_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .scl_lvl   (scl_lvl),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .busy      (busy),
    .dev_phase (dev_phase),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .wp        (wp_i),
    .ptr       (ptr_now)
);

// File: tb/sim_spd_i2c_slave.sv
module sim_spd_i2c_slave;
    localparam int BUSY = 400;
    localparam int Q    = 6;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wp    = 1'b0;
    logic [2:0] strap = 3'b000;
    logic       sda_oe;
    logic       sda_line;

    int   checks = 0;
    int   errors = 0;
    int   model_mem [256];
    int   model_ptr = 0;
    bit   quiet = 1'b0;
    bit   done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] wq [$];

    assign sda_line = m_sda & ~sda_oe;

    spd_i2c_slave #(.BUSY_CYCLES(BUSY)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .strap_i  (strap),
        .wp_i     (wp)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the bus rules
    always @(posedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_oe) chk(m_scl == 1'b0, "R11", int'(m_scl), 0);
            if (quiet) chk(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
            prev_oe <= sda_oe;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input bit rw);
        return {4'b1010, strap, rw};
    endfunction

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input bit b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output bit b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic get_byte(output logic [7:0] v, input bit give_ack);
        bit x;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(x);
            v = {v[6:0], x};
        end
        put_bit(!give_ack);
    endtask

    task automatic wr_seq(input logic [7:0] addr, input bit wait_busy, input string req);
        bit ack;
        i2c_start();
        put_byte(dev(1'b0), ack); chk(ack, "R2", int'(ack), 1);
        put_byte(addr, ack);      chk(ack, req, int'(ack), 1);
        model_ptr = int'(addr);
        foreach (wq[k]) begin
            put_byte(wq[k], ack);
            chk(ack, req, int'(ack), 1);
            if (!(wp && model_ptr >= 128)) model_mem[model_ptr] = int'(wq[k]);
            model_ptr = (model_ptr + 1) % 256;
        end
        i2c_stop();
        if (wait_busy) tick(BUSY + 40);
    endtask

    task automatic rd_seq(input bit set_addr, input logic [7:0] addr, input int n, input string req);
        bit ack;
        logic [7:0] v;
        if (set_addr) begin
            i2c_start();
            put_byte(dev(1'b0), ack); chk(ack, "R2", int'(ack), 1);
            put_byte(addr, ack);      chk(ack, "R12", int'(ack), 1);
            model_ptr = int'(addr);
        end
        i2c_start();
        put_byte(dev(1'b1), ack); chk(ack, "R12", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            get_byte(v, k != n - 1);
            chk(int'(v) == model_mem[model_ptr], req, int'(v), model_mem[model_ptr]);
            model_ptr = (model_ptr + 1) % 256;
        end
        i2c_stop();
        tick(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        bit x;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) model_mem[i] = (i ^ 8'hA5) & 8'hFF;
        tick(10);
        rst_n = 1'b1;
        tick(4);
        chk(sda_oe == 1'b0, "R10", int'(sda_oe), 0);

        // R1: address-shaped traffic with no START must stay unanswered
        quiet = 1'b1;
        m_scl = 1'b0; tick(Q);
        for (int i = 7; i >= 0; i--) put_bit(dev(1'b0)[i]);
        get_bit(x);
        chk(x == 1'b1, "R1", int'(x), 1);
        quiet = 1'b0;
        m_scl = 1'b1; tick(Q);
        i2c_stop();

        // R10: reset content and pointer at 0 via current-address read
        rd_seq(1'b0, 8'h00, 2, "R10");

        // R2: wrong strap and wrong device code are not answered
        i2c_start();
        put_byte(8'b1010_011_0, ack); chk(!ack, "R2", int'(ack), 0);
        put_byte(8'h00, ack);         chk(!ack, "R2", int'(ack), 0);
        i2c_stop();
        i2c_start();
        put_byte(8'b1011_000_0, ack); chk(!ack, "R2", int'(ack), 0);
        i2c_stop();

        // R3: multi-byte write, then R5/R12 random read back
        wq = '{8'h11, 8'h22, 8'h33};
        wr_seq(8'h10, 1'b1, "R3");
        rd_seq(1'b1, 8'h10, 3, "R5");

        // R7: current-address read continues from 0x13
        rd_seq(1'b0, 8'h00, 2, "R7");

        // R4: wrap across 255 -> 0
        wq = '{8'hC1, 8'hC2, 8'hC3};
        wr_seq(8'hFE, 1'b1, "R4");
        rd_seq(1'b1, 8'hFE, 3, "R4");

        // R8: protected upper half with wp high
        wp = 1'b1;
        wq = '{8'h5A, 8'h6B, 8'h7C};
        wr_seq(8'h7E, 1'b1, "R8");
        rd_seq(1'b1, 8'h7E, 3, "R8");
        wp = 1'b0;

        // R6: no acknowledge ends the read; the line stays released
        i2c_start();
        put_byte(dev(1'b1), ack); chk(ack, "R2", int'(ack), 1);
        get_byte(v, 1'b0);
        chk(int'(v) == model_mem[model_ptr], "R6", int'(v), model_mem[model_ptr]);
        model_ptr = (model_ptr + 1) % 256;
        for (int i = 0; i < 8; i++) begin
            get_bit(x);
            chk(x == 1'b1, "R6", int'(x), 1);
        end
        i2c_stop();

        // R9: busy window after a data write
        wq = '{8'h99};
        wr_seq(8'h30, 1'b0, "R3");
        i2c_start();
        put_byte(dev(1'b0), ack); chk(!ack, "R9", int'(ack), 0);
        i2c_stop();
        tick(BUSY + 40);
        i2c_start();
        put_byte(dev(1'b0), ack); chk(ack, "R9", int'(ack), 1);
        put_byte(8'h30, ack);     chk(ack, "R9", int'(ack), 1);
        model_ptr = 8'h30;
        i2c_stop();
        tick(Q);
        rd_seq(1'b0, 8'h00, 1, "R9");

        // R2: other strap setting answers its own address
        strap = 3'b101;
        rd_seq(1'b1, 8'h10, 2, "R2");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule